// File: doc/BRIEF.md
# Byte-Lane Memory Slave for a Classic Wishbone Bus

This block is a classic-cycle Wishbone slave with a small word-organised memory behind it. A master starts an access by raising cycle and strobe together. The slave samples the bus on one clock edge, which a parameter selects as rising or falling. It handles one access at a time and answers it with a single one-cycle response, either acknowledge or error, and never with retry.

The byte-select vector must be one unbroken run of set lanes. The number of set lanes is the transfer length. The low address bits give the byte position inside the word, and the upper address bits give the word index. A second parameter turns on byte reversal between the bus and the storage: write data is mirrored before it is stored, and read data is mirrored after it is fetched. The block also computes a lane position from the select vector, mirrored in reversal mode. When that lane position disagrees with the address byte position, the block sets a sticky flag.

Top module: `wb_mem_port`

## Requirements
- R1: With `NEG_EDGE`=1 the bus is sampled and the response launched on the falling clock edge. With `NEG_EDGE`=0 the rising edge is used.
- R2: An access is taken only when `wbCyc` and `wbStb` are both high and no access is pending. Its response is visible for exactly the one active-edge period after the edge that took it. The port is then idle again, and a bus with only one of cyc or stb high gets no response and changes no memory.
- R3: A completed access raises exactly one of `wbAck` or `wbErr` for that period. `wbRty` is always 0.
- R4: When no response is presented, `wbAck`, `wbErr` and `wbDatOut` are all 0.
- R5: Bits [ADDR_W-1:log2(DATA_BYTES)] of `wbAdr` select the word, and the low bits give the byte offset. A write of length L stores bus lanes offset to offset+L-1 into the same lanes of the word.
- R6: `wbSel` is valid only if it is non-zero and its set bits are contiguous. Any other pattern completes with `wbErr`, leaves memory unchanged and returns read data 0.
- R7: A word index of MEM_WORDS or higher, or a byte offset plus length above DATA_BYTES, completes with `wbErr`. It does not write and does not alias onto another word.
- R8: A good read returns the stored bytes in lanes offset to offset+L-1 and 0 in every other lane.
- R9: With `SWAP_BYTES`=1, lane i of the write data is stored in lane DATA_BYTES-1-i before the lane range is applied. The fetched read lanes are mirrored the same way before output.
- R10: For a valid `wbSel`, the lane position is the number of trailing zero bits of `wbSel`. In reversal mode it is DATA_BYTES minus length minus that number. When the lane position differs from the address byte offset, `laneMismatch` rises and stays high until reset.
- R11: After reset the outputs `wbAck`, `wbErr`, `wbRty`, `wbDatOut` and `laneMismatch` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wbCyc | input | 1 | Bus cycle active |
| wbStb | input | 1 | Transfer strobe |
| wbWe | input | 1 | 1 = write, 0 = read |
| wbAdr | input | ADDR_W | Byte address |
| wbSel | input | DATA_BYTES | Byte-lane select |
| wbDatIn | input | 8*DATA_BYTES | Write data |
| wbDatOut | output | 8*DATA_BYTES | Read data, 0 outside a read response |
| wbAck | output | 1 | Successful completion |
| wbErr | output | 1 | Failed completion |
| wbRty | output | 1 | Retry, held at 0 |
| laneMismatch | output | 1 | Sticky select/address offset disagreement |

## Verification
The bench drives two copies of the block in parallel: one with default settings, and one that samples on the falling edge and reverses bytes. It checks each copy against its own byte-level memory model. A design that ignored the edge parameter would respond to the falling-edge copy half a cycle late. A design that accepted a gapped select, such as 0101, would acknowledge it and corrupt the word. The bench writes address 0x400, which aliases onto word 0 if the upper address bits are dropped, and then reads word 0 to catch that truncation. It also drives cyc without stb, and stb without cyc, and checks that neither produces a response or a write. Finally, it reads back partial and reversed transfers with lane-exact expected data, so a wrong mirror or lane mask shows up as bytes in the wrong position.

// File: rtl/wb_mem_pkg.sv
package wb_mem_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } accState_t;

  typedef struct packed {
    logic accept;
    logic commitWrite;
    logic captureRead;
  } dpStrobes_t;

endpackage

// File: rtl/wb_sel_decode.sv
module wb_sel_decode #(
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES),
  localparam int LEN_W = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0] sel,
  output logic             selValid,
  output logic [LEN_W-1:0] runLen,
  output logic [OFF_W-1:0] runStart
);

  logic [LANES-1:0] shifted;
  logic             found;

  always_comb begin
    runStart = '0;
    found    = 1'b0;
    runLen   = '0;
    for (int k = 0; k < LANES; k++) begin
      if (!found && sel[k]) begin
        runStart = OFF_W'(k);
        found    = 1'b1;
      end
      runLen = runLen + LEN_W'(sel[k]);
    end
    shifted  = sel >> runStart;
    selValid = found && ((shifted & (shifted + 1'b1)) == '0);
  end

endmodule

// File: rtl/wb_mem_ctrl.sv
module wb_mem_ctrl
  import wb_mem_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cyc,
  input  logic       stb,
  input  logic       we,
  input  logic       accessFault,
  output dpStrobes_t strobes,
  output logic       ack,
  output logic       err,
  output logic       rty
);

  accState_t state;
  logic      errFlag;
  logic      accept;

  assign accept = (state == ST_IDLE) && cyc && stb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      errFlag <= 1'b0;
    end else if (accept) begin
      state   <= we ? ST_WRITE : ST_READ;
      errFlag <= accessFault;
    end else begin
      state   <= ST_IDLE;
      errFlag <= 1'b0;
    end
  end

  always_comb begin
    strobes.accept      = accept;
    strobes.commitWrite = accept && we && !accessFault;
    strobes.captureRead = accept && !we && !accessFault;
  end

  assign ack = (state != ST_IDLE) && !errFlag;
  assign err = (state != ST_IDLE) && errFlag;
  assign rty = 1'b0;

endmodule

// File: rtl/wb_mem_datapath.sv
module wb_mem_datapath
  import wb_mem_pkg::*;
#(
  parameter int DATA_BYTES = 4,
  parameter int MEM_WORDS  = 256,
  parameter int ADDR_W     = 32,
  parameter bit SWAP_BYTES = 1'b0,
  localparam int DATA_W = 8 * DATA_BYTES,
  localparam int OFF_W  = $clog2(DATA_BYTES),
  localparam int LEN_W  = $clog2(DATA_BYTES + 1),
  localparam int END_W  = OFF_W + 2,
  localparam int WADR_W = ADDR_W - OFF_W,
  localparam int IDX_W  = $clog2(MEM_WORDS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobes_t            strobes,
  input  logic [ADDR_W-1:0]     adr,
  input  logic [DATA_BYTES-1:0] sel,
  input  logic [DATA_W-1:0]     datIn,
  output logic                  accessFault,
  output logic [DATA_W-1:0]     datOut,
  output logic                  laneMismatch
);

  logic                  selValid;
  logic [LEN_W-1:0]      runLen;
  logic [OFF_W-1:0]      runStart;
  logic [OFF_W-1:0]      addrOff;
  logic [WADR_W-1:0]     wordAddr;
  logic [IDX_W-1:0]      memIdx;
  logic                  inRange;
  logic                  spanFits;
  logic [END_W-1:0]      spanEnd;
  logic [END_W-1:0]      laneOffEff;
  logic                  offMismatch;
  logic [DATA_BYTES-1:0] laneMask;
  logic [DATA_W-1:0]     datInRev;
  logic [DATA_W-1:0]     writeBuf;
  logic [DATA_W-1:0]     memWord;
  logic [DATA_W-1:0]     readRaw;
  logic [DATA_W-1:0]     readRawRev;
  logic [DATA_W-1:0]     readOut;
  logic [DATA_W-1:0]     mem [MEM_WORDS];

  wb_sel_decode #(.LANES(DATA_BYTES)) i_selDecode (
    .sel      (sel),
    .selValid (selValid),
    .runLen   (runLen),
    .runStart (runStart)
  );

  assign addrOff  = adr[OFF_W-1:0];
  assign wordAddr = adr[ADDR_W-1:OFF_W];
  assign memIdx   = wordAddr[IDX_W-1:0];
  assign inRange  = wordAddr < WADR_W'(MEM_WORDS);
  assign spanEnd  = END_W'(addrOff) + END_W'(runLen);
  assign spanFits = spanEnd <= END_W'(DATA_BYTES);

  assign accessFault = !selValid || !inRange || !spanFits;

  generate
    if (SWAP_BYTES) begin : g_mirrorOff
      assign laneOffEff = END_W'(DATA_BYTES) - END_W'(runLen) - END_W'(runStart);
    end else begin : g_plainOff
      assign laneOffEff = END_W'(runStart);
    end
  endgenerate

  assign offMismatch = selValid && (laneOffEff != END_W'(addrOff));

  for (genvar k = 0; k < DATA_BYTES; k++) begin : g_lane
    assign laneMask[k] = (END_W'(k) >= END_W'(addrOff)) && (END_W'(k) < spanEnd);
    assign datInRev[k*8 +: 8]   = datIn[(DATA_BYTES-1-k)*8 +: 8];
    assign readRaw[k*8 +: 8]    = laneMask[k] ? memWord[k*8 +: 8] : 8'h00;
    assign readRawRev[k*8 +: 8] = readRaw[(DATA_BYTES-1-k)*8 +: 8];
  end

  generate
    if (SWAP_BYTES) begin : g_swap
      assign writeBuf = datInRev;
      assign readOut  = readRawRev;
    end else begin : g_noSwap
      assign writeBuf = datIn;
      assign readOut  = readRaw;
    end
  endgenerate

  assign memWord = mem[memIdx];

  always_ff @(posedge clk) begin
    if (strobes.commitWrite) begin
      for (int k = 0; k < DATA_BYTES; k++) begin
        if (laneMask[k]) mem[memIdx][k*8 +: 8] <= writeBuf[k*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      datOut       <= '0;
      laneMismatch <= 1'b0;
    end else begin
      datOut       <= strobes.captureRead ? readOut : '0;
      laneMismatch <= laneMismatch || (strobes.accept && offMismatch);
    end
  end

endmodule

// File: rtl/wb_mem_port.sv
module wb_mem_port
  import wb_mem_pkg::*;
#(
  parameter int DATA_BYTES = 4,
  parameter int MEM_WORDS  = 256,
  parameter int ADDR_W     = 32,
  parameter bit NEG_EDGE   = 1'b0,
  parameter bit SWAP_BYTES = 1'b0,
  localparam int DATA_W = 8 * DATA_BYTES
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wbCyc,
  input  logic                  wbStb,
  input  logic                  wbWe,
  input  logic [ADDR_W-1:0]     wbAdr,
  input  logic [DATA_BYTES-1:0] wbSel,
  input  logic [DATA_W-1:0]     wbDatIn,
  output logic [DATA_W-1:0]     wbDatOut,
  output logic                  wbAck,
  output logic                  wbErr,
  output logic                  wbRty,
  output logic                  laneMismatch
);

  logic       activeClk;
  logic       accessFault;
  dpStrobes_t strobes;

  generate
    if (NEG_EDGE) begin : g_fallClk
      assign activeClk = ~clk;
    end else begin : g_riseClk
      assign activeClk = clk;
    end
  endgenerate

  wb_mem_ctrl i_ctrl (
    .clk         (activeClk),
    .rstN        (rstN),
    .cyc         (wbCyc),
    .stb         (wbStb),
    .we          (wbWe),
    .accessFault (accessFault),
    .strobes     (strobes),
    .ack         (wbAck),
    .err         (wbErr),
    .rty         (wbRty)
  );

  wb_mem_datapath #(
    .DATA_BYTES (DATA_BYTES),
    .MEM_WORDS  (MEM_WORDS),
    .ADDR_W     (ADDR_W),
    .SWAP_BYTES (SWAP_BYTES)
  ) i_datapath (
    .clk          (activeClk),
    .rstN         (rstN),
    .strobes      (strobes),
    .adr          (wbAdr),
    .sel          (wbSel),
    .datIn        (wbDatIn),
    .accessFault  (accessFault),
    .datOut       (wbDatOut),
    .laneMismatch (laneMismatch)
  );

endmodule

// File: rtl/wb_mem_port_chk.sv
module wb_mem_port_chk #(
  parameter int DATA_BYTES = 4,
  localparam int DATA_W = 8 * DATA_BYTES
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  cyc,
  input logic                  stb,
  input logic [DATA_BYTES-1:0] sel,
  input logic [DATA_W-1:0]     datOut,
  input logic                  ack,
  input logic                  err,
  input logic                  rty,
  input logic                  laneMismatch
);

  assert_resp_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(ack && err));

  assert_no_retry_R3: assert property (@(posedge clk) disable iff (!rstN)
    !rty);

  assert_take_request_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cyc && stb && !ack && !err) |=> (ack || err));

  assert_single_beat_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ack || err) |=> !(ack || err));

  assert_quiet_data_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(ack || err) |-> (datOut == '0));

  assert_empty_sel_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cyc && stb && !ack && !err && sel == '0) |=> err);

  assert_sticky_flag_R10: assert property (@(posedge clk) disable iff (!rstN)
    laneMismatch |=> laneMismatch);

endmodule

bind wb_mem_port wb_mem_port_chk #(.DATA_BYTES(DATA_BYTES)) i_chk (
  .clk          (activeClk),
  .rstN         (rstN),
  .cyc          (wbCyc),
  .stb          (wbStb),
  .sel          (wbSel),
  .datOut       (wbDatOut),
  .ack          (wbAck),
  .err          (wbErr),
  .rty          (wbRty),
  .laneMismatch (laneMismatch)
);

// File: tb/test_wb_mem_port.sv
`timescale 1ns/1ps
module test_wb_mem_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wbCyc = 1'b0, wbStb = 1'b0, wbWe = 1'b0;
  logic [31:0] wbAdr = '0, wbDatIn = '0;
  logic [3:0]  wbSel = '0;
  logic [31:0] datA, datB;
  logic        ackA, errA, rtyA, misA, ackB, errB, rtyB, misB;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct packed {
    logic        ackA, errA, misA;
    logic [31:0] datA;
    logic        ackB, errB, misB;
    logic [31:0] datB;
  } expItem_t;

  expItem_t expQ[$];
  string    tagQ[$];
  logic [31:0] modelMem [2][256];
  logic        modelMis [2];

  always #4 clk = ~clk;

  wb_mem_port i_wb_mem_port (
    .clk(clk), .rstN(rstN), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .wbAdr(wbAdr), .wbSel(wbSel), .wbDatIn(wbDatIn), .wbDatOut(datA),
    .wbAck(ackA), .wbErr(errA), .wbRty(rtyA), .laneMismatch(misA));

  wb_mem_port #(.NEG_EDGE(1'b1), .SWAP_BYTES(1'b1)) i_wb_mem_port_swap (
    .clk(clk), .rstN(rstN), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .wbAdr(wbAdr), .wbSel(wbSel), .wbDatIn(wbDatIn), .wbDatOut(datB),
    .wbAck(ackB), .wbErr(errB), .wbRty(rtyB), .laneMismatch(misB));

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mirror(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  // Byte-level model of one port; u=1 is the reversing copy.
  task automatic model(input int u, input logic [31:0] adr, input logic [3:0] sel,
                       input logic we, input logic [31:0] wd,
                       output logic errO, output logic [31:0] rdO);
    int cnt = 0, tz = 0, off, lo;
    bit seen = 0, valid;
    logic [31:0] buff, word;
    for (int k = 0; k < 4; k++) begin
      if (sel[k]) begin cnt++; if (!seen) begin tz = k; seen = 1; end end
    end
    valid = (cnt > 0) && (sel == 4'(((1 << cnt) - 1) << tz));
    off = int'(adr[1:0]);
    errO = !valid || (adr[31:2] >= 30'd256) || (off + cnt > 4);
    rdO = '0;
    if (valid) begin
      lo = (u == 1) ? (4 - cnt - tz) : tz;
      if (lo != off) modelMis[u] = 1'b1;
    end
    if (!errO) begin
      word = modelMem[u][adr[9:2]];
      if (we) begin
        buff = (u == 1) ? mirror(wd) : wd;
        for (int k = off; k < off + cnt; k++) word[k*8 +: 8] = buff[k*8 +: 8];
        modelMem[u][adr[9:2]] = word;
      end else begin
        buff = '0;
        for (int k = off; k < off + cnt; k++) buff[k*8 +: 8] = word[k*8 +: 8];
        rdO = (u == 1) ? mirror(buff) : buff;
      end
    end
  endtask

  task automatic access(input logic c, input logic s, input logic we, input logic [31:0] adr,
                        input logic [3:0] sel, input logic [31:0] wd, input string tag);
    expItem_t it;
    logic eA, eB;
    logic [31:0] rA, rB;
    bit taken = c && s;
    if (taken) begin
      model(0, adr, sel, we, wd, eA, rA);
      model(1, adr, sel, we, wd, eB, rB);
      it.ackA = !eA; it.errA = eA; it.datA = rA; it.misA = modelMis[0];
      it.ackB = !eB; it.errB = eB; it.datB = rB; it.misB = modelMis[1];
      expQ.push_back(it);
      tagQ.push_back(tag);
    end
    @(posedge clk); #1;
    wbCyc = c; wbStb = s; wbWe = we; wbAdr = adr; wbSel = sel; wbDatIn = wd;
    #5;
    // R1: falling-edge copy has answered, rising-edge copy not yet
    check((ackB || errB) == taken, {tag, " R1 fall-edge response"}, 64'(ackB || errB), 64'(taken));
    check(!(ackA || errA), {tag, " R1 rise-edge early"}, 64'(ackA || errA), 64'd0);
    @(posedge clk); #1;
    wbCyc = 0; wbStb = 0; wbWe = 0; wbSel = '0; wbDatIn = '0;
    @(posedge clk);
  endtask

  // Scoreboard monitor
  initial begin
    expItem_t it;
    string tag;
    wait (rstN);
    forever begin
      @(posedge clk); #2;
      check(!rtyA && !rtyB, "R3 retry low", 64'({rtyA, rtyB}), 64'd0);
      if (ackA || errA) begin
        if (expQ.size() == 0) begin
          check(0, "R2 unexpected response", 64'({ackA, errA}), 64'd0);
        end else begin
          it = expQ.pop_front();
          tag = tagQ.pop_front();
          check({ackA, errA} == {it.ackA, it.errA}, {tag, " R3 resp plain"}, 64'({ackA, errA}), 64'({it.ackA, it.errA}));
          check(datA == it.datA, {tag, " R8 data plain"}, 64'(datA), 64'(it.datA));
          check(misA == it.misA, {tag, " R10 flag plain"}, 64'(misA), 64'(it.misA));
          check({ackB, errB} == {it.ackB, it.errB}, {tag, " R3 resp swap"}, 64'({ackB, errB}), 64'({it.ackB, it.errB}));
          check(datB == it.datB, {tag, " R9 data swap"}, 64'(datB), 64'(it.datB));
          check(misB == it.misB, {tag, " R10 flag swap"}, 64'(misB), 64'(it.misB));
        end
      end else begin
        check(datA == '0 && !(ackB || errB) && datB == '0, "R4 idle outputs",
              64'({datA, datB}), 64'd0);
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      check(0, "watchdog expired", 64'd0, 64'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    modelMis[0] = 0; modelMis[1] = 0;
    repeat (3) @(posedge clk);
    #1;
    check({ackA, errA, rtyA, misA, datA} == '0, "R11 reset plain", 64'({ackA, errA, rtyA, misA, datA}), 64'd0);
    check({ackB, errB, rtyB, misB, datB} == '0, "R11 reset swap", 64'({ackB, errB, rtyB, misB, datB}), 64'd0);
    rstN = 1'b1;

    access(1, 1, 1, 32'h14, 4'hF, 32'h11223344, "R5 full write");
    access(1, 1, 0, 32'h14, 4'hF, 32'h0, "R9 full readback");
    access(1, 1, 1, 32'h16, 4'h4, 32'h00AA0000, "R5 byte write lane2");
    access(1, 1, 0, 32'h16, 4'h4, 32'h0, "R8 byte read lane2");
    access(1, 1, 0, 32'h14, 4'h3, 32'h0, "R8 half read");
    access(1, 1, 1, 32'h14, 4'h5, 32'hFFFFFFFF, "R6 gapped sel write");
    access(1, 1, 0, 32'h14, 4'h0, 32'h0, "R6 empty sel");
    access(1, 1, 0, 32'h14, 4'hF, 32'h0, "R6 word unchanged");
    access(1, 1, 1, 32'h0, 4'hF, 32'hCAFEF00D, "R5 word0 write");
    access(1, 1, 1, 32'h400, 4'hF, 32'hDEADBEEF, "R7 beyond range write");
    access(1, 1, 0, 32'h0, 4'hF, 32'h0, "R7 no alias");
    access(1, 1, 1, 32'h3FC, 4'hF, 32'h5A5A0F0F, "R5 last word write");
    access(1, 1, 0, 32'h3FC, 4'h6, 32'h0, "R8 last word mid read");
    access(1, 0, 1, 32'h14, 4'hF, 32'h99999999, "R2 cyc only");
    access(0, 1, 1, 32'h14, 4'hF, 32'h99999999, "R2 stb only");
    access(1, 1, 0, 32'h14, 4'hF, 32'h0, "R2 ignored writes");
    access(1, 1, 0, 32'h17, 4'h3, 32'h0, "R7 span overflow");
    access(1, 1, 0, 32'h14, 4'h8, 32'h0, "R10 lane mismatch read");
    access(1, 1, 0, 32'h0, 4'hF, 32'h0, "R10 flag stays");

    repeat (4) @(posedge clk);
    check(expQ.size() == 0, "R2 missing responses", 64'(expQ.size()), 64'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule